// File: doc/BRIEF.md
# SPI Status Flag Controller

This block holds the three status flags of a byte-wide SPI peripheral whose status and data registers sit on a processor bus. The flags are transfer complete, write collision and mode fault. It collects events from the shifter, the slave-select pin and the bus, and presents them as one status byte. It also raises a level interrupt request when a completed transfer is enabled to interrupt. Finally, it tells the data-register logic whether a write issued now would be accepted.

Software acknowledges a flag in two steps. First it reads the status register while the flag is set, which arms that flag. Then any read or write of the data register clears every armed flag. If a flag's event occurs again after the arming read, that flag is disarmed, so the access does not hide the new event. Which cycles count as "transfer in progress" for collision detection depends on the clock-phase setting. The shift register and the serial clock generator are outside this block.

The bus side is a read strobe, a write strobe and a one-bit register select, where 0 addresses status and 1 addresses data. All inputs are synchronous to `clk`.

Top module: `spi_flag_ctrl`

## Requirements
- R1: `stat_byte` carries transfer-complete at bit 7, write-collision at bit 6 and mode-fault at bit 4. Bits 5, 3, 2, 1 and 0 always read 0, and every bit is 0 after reset.
- R2: A `byte_done` pulse sets the transfer-complete flag, which is visible on `stat_byte` from the following cycle.
- R3: Transfer-complete clears only on a data-register access (read or write, `reg_sel`=1) that follows a status read (`bus_rd` with `reg_sel`=0) that saw the flag set. A data access without such a read leaves the flag set.
- R4: While transfer-complete is set and no status read has yet seen it, `data_wr_ok` is 0. After such a read, `data_wr_ok` is 1 unless a transfer is in progress.
- R5: A data-register write while a transfer is in progress sets the write-collision flag, and during that window `data_wr_ok` is 0.
- R6: With `cfg_cpha`=0, a transfer is in progress whenever `ss_n` is low.
- R7: With `cfg_cpha`=1, a transfer is in progress from the first cycle in which `sck_active` is high while `ss_n` is low, up to and including the cycle of `byte_done`. `ss_n` low alone opens no window.
- R8: `irq` is high exactly while transfer-complete and `cfg_irq_en` are both 1, and it drops in the cycle the flag clears.
- R9: A flag's setting event in the same cycle as, or later than, the arming status read disarms it. The next data access then leaves the flag set, and a set event wins over a clear in the same cycle.
- R10: Writes to the status register (`bus_wr` with `reg_sel`=0) change no flag and arm nothing.
- R11: Write-collision clears on a data access that follows a status read that saw it set, with the same disarming rule as R9.
- R12: Mode-fault sets in every cycle in which `cfg_master`=1 and `ss_n`=0. It clears by the same two-step sequence only once that condition has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd | input | 1 | Bus read strobe, one cycle per access |
| bus_wr | input | 1 | Bus write strobe, one cycle per access |
| reg_sel | input | 1 | Register select: 0 status, 1 data |
| cfg_cpha | input | 1 | Clock-phase configuration bit |
| cfg_irq_en | input | 1 | Interrupt-enable configuration bit |
| cfg_master | input | 1 | Master-mode configuration bit |
| ss_n | input | 1 | Slave-select pin level, active low |
| sck_active | input | 1 | Serial clock is toggling this cycle |
| byte_done | input | 1 | One-cycle pulse from the shifter at the end of a byte |
| stat_byte | output | 8 | Status register read value |
| irq | output | 1 | Level interrupt request |
| data_wr_ok | output | 1 | A data-register write this cycle would be accepted |

## Verification
Two functions can fall in the same cycle: setting a flag and clearing it through the data access that completes the acknowledge sequence. The bench provokes this by pulsing `byte_done` in the same cycle as the data read that should clear transfer-complete, and again with a new `byte_done` between the arming status read and that access. In both cases the flag must still read 1 afterwards. A second overlap is a colliding data write that is also the clearing access for write-collision. That write must leave write-collision set rather than cleared.

// File: rtl/spi_flag_ctrl.sv
module spi_flag_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_rd,
  input  logic       bus_wr,
  input  logic       reg_sel,
  input  logic       cfg_cpha,
  input  logic       cfg_irq_en,
  input  logic       cfg_master,
  input  logic       ss_n,
  input  logic       sck_active,
  input  logic       byte_done,
  output logic [7:0] stat_byte,
  output logic       irq,
  output logic       data_wr_ok
);

  localparam int NF     = 3;
  localparam int F_DONE = 2;
  localparam int F_WCOL = 1;
  localparam int F_MODF = 0;

  logic [NF-1:0] flag_q, arm_q, set_ev, clr_mask, arm_add;
  logic          stat_rd, data_acc, phase_q, win_cpha1, busy;

  assign stat_rd  = bus_rd & ~reg_sel;
  assign data_acc = (bus_rd | bus_wr) & reg_sel;

  // clock-phase 1 window: opens on serial clock activity under select, closes at byte end
  assign win_cpha1 = phase_q | (sck_active & ~ss_n);
  assign busy      = cfg_cpha ? win_cpha1 : ~ss_n;

  always_ff @(posedge clk) begin
    if (!rst_n)                       phase_q <= 1'b0;
    else if (!cfg_cpha || byte_done)  phase_q <= 1'b0;
    else if (sck_active && !ss_n)     phase_q <= 1'b1;
  end

  assign set_ev[F_DONE] = byte_done;
  assign set_ev[F_WCOL] = bus_wr & reg_sel & busy;
  assign set_ev[F_MODF] = cfg_master & ~ss_n;

  assign clr_mask = data_acc ? arm_q : '0;
  assign arm_add  = stat_rd ? flag_q : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= '0;
      arm_q  <= '0;
    end else begin
      flag_q <= set_ev | (flag_q & ~clr_mask);
      arm_q  <= ~set_ev & (data_acc ? '0 : (arm_q | arm_add));
    end
  end

  assign stat_byte  = {flag_q[F_DONE], flag_q[F_WCOL], 1'b0, flag_q[F_MODF], 4'b0000};
  assign irq        = flag_q[F_DONE] & cfg_irq_en;
  assign data_wr_ok = ~busy & (~flag_q[F_DONE] | arm_q[F_DONE]);

  AST_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> stat_byte[7]);                                                  // R2
  AST_DONE_CLR_BY_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    stat_byte[7] && !data_acc |=> stat_byte[7]);                                  // R3
  AST_WR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    stat_byte[7] && !arm_q[F_DONE] |-> !data_wr_ok);                              // R4
  AST_WCOL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && reg_sel && busy |=> stat_byte[6]);                                  // R5
  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_byte[7] |-> !irq);                                                      // R8
  AST_STAT_WR_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && !reg_sel && !byte_done && !(cfg_master && !ss_n) |=> $stable(stat_byte)); // R10
  AST_MODF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_master && !ss_n |=> stat_byte[4]);                                        // R12

endmodule

// File: tb/spi_flag_ctrl_bench.sv
module spi_flag_ctrl_bench;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n, bus_rd, bus_wr, reg_sel, cfg_cpha, cfg_irq_en, cfg_master, ss_n, sck_active, byte_done;
  logic [7:0] stat_byte;
  logic irq, data_wr_ok;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_flag_ctrl u_spi_flag_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .reg_sel(reg_sel),
    .cfg_cpha(cfg_cpha), .cfg_irq_en(cfg_irq_en), .cfg_master(cfg_master), .ss_n(ss_n),
    .sck_active(sck_active), .byte_done(byte_done), .stat_byte(stat_byte), .irq(irq),
    .data_wr_ok(data_wr_ok));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic bus(input logic rd, input logic wr, input logic sel);
    bus_rd = rd; bus_wr = wr; reg_sel = sel;
    tick();
    bus_rd = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic pulse_done();
    byte_done = 1'b1;
    tick();
    byte_done = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bus_rd = 0; bus_wr = 0; reg_sel = 0; cfg_cpha = 0; cfg_irq_en = 0;
    cfg_master = 0; ss_n = 1; sck_active = 0; byte_done = 0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 reset status", stat_byte, 8'h00);
    chk("R8 reset irq", {7'b0, irq}, 8'h00);
    chk("R4 reset permit", {7'b0, data_wr_ok}, 8'h01);
  endtask

  task automatic t_done();
    do_reset();
    pulse_done();
    chk("R2 done set", stat_byte, 8'h80);
    chk("R8 irq off when disabled", {7'b0, irq}, 8'h00);
    cfg_irq_en = 1'b1; #1;
    chk("R8 irq on when enabled", {7'b0, irq}, 8'h01);
    chk("R4 write blocked", {7'b0, data_wr_ok}, 8'h00);
    bus(0, 1, 1);
    chk("R3 unarmed access keeps flag", stat_byte, 8'h80);
    bus(1, 0, 0);
    chk("R4 permit after read", {7'b0, data_wr_ok}, 8'h01);
    bus(1, 0, 1);
    chk("R3 two-step clear", stat_byte, 8'h00);
    chk("R8 irq drops", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_rearm();
    do_reset();
    pulse_done();
    bus(1, 0, 0);
    pulse_done();
    bus(1, 0, 1);
    chk("R9 reset after read survives", stat_byte, 8'h80);
    bus(1, 0, 0);
    byte_done = 1'b1;
    bus(1, 0, 1);
    byte_done = 1'b0;
    chk("R9 set beats clear same cycle", stat_byte, 8'h80);
    bus(1, 0, 0);
    bus(0, 1, 1);
    chk("R3 clear by data write", stat_byte, 8'h00);
  endtask

  task automatic t_stat_wr();
    do_reset();
    pulse_done();
    bus(0, 1, 0); bus(0, 1, 0);
    chk("R10 status write keeps flag", stat_byte, 8'h80);
    chk("R10 status write does not arm", {7'b0, data_wr_ok}, 8'h00);
    bus(1, 0, 1);
    chk("R10 access after status write no clear", stat_byte, 8'h80);
  endtask

  task automatic t_cpha0();
    do_reset();
    ss_n = 1'b0; tick();
    chk("R6 window under select", {7'b0, data_wr_ok}, 8'h00);
    bus(0, 1, 1);
    chk("R5 collision sets", stat_byte, 8'h40);
    bus(1, 0, 0);
    bus(0, 1, 1);
    chk("R11 colliding clear access keeps flag", stat_byte, 8'h40);
    bus(1, 0, 0);
    bus(1, 0, 1);
    chk("R11 two-step clear", stat_byte, 8'h00);
    ss_n = 1'b1; tick();
    bus(0, 1, 1);
    chk("R6 no collision when deselected", stat_byte, 8'h00);
  endtask

  task automatic t_cpha1();
    do_reset();
    cfg_cpha = 1'b1; ss_n = 1'b0; tick();
    chk("R7 select alone no window", {7'b0, data_wr_ok}, 8'h01);
    bus(0, 1, 1);
    chk("R7 no collision before clock", stat_byte, 8'h00);
    sck_active = 1'b1; tick(); sck_active = 1'b0; tick();
    chk("R7 window after clock", {7'b0, data_wr_ok}, 8'h00);
    bus(0, 1, 1);
    chk("R5 collision in phase 1", stat_byte, 8'h40);
    pulse_done();
    chk("R7 both flags", stat_byte, 8'hC0);
    bus(1, 0, 0);
    chk("R7 window closed at byte end", {7'b0, data_wr_ok}, 8'h01);
    bus(0, 1, 1);
    chk("R11 both flags cleared", stat_byte, 8'h00);
  endtask

  task automatic t_modf();
    do_reset();
    ss_n = 1'b0; tick();
    chk("R12 slave no fault", stat_byte, 8'h00);
    cfg_master = 1'b1; tick();
    chk("R12 fault sets", stat_byte, 8'h10);
    bus(1, 0, 0);
    bus(1, 0, 1);
    chk("R12 no clear while condition", stat_byte, 8'h10);
    ss_n = 1'b1; tick();
    bus(1, 0, 0);
    bus(1, 0, 1);
    chk("R12 clear after condition", stat_byte, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_done();
    t_rearm();
    t_stat_wr();
    t_cpha0();
    t_cpha1();
    t_modf();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule